// File: doc/BRIEF.md
# Non-Cacheable Region Address Checker

This block sits beside an instruction cache and decides, for each fetch address, whether the address falls inside a region that must bypass the cache. It holds two programmable 32-bit address registers and one mode bit. Together they describe one region. The result is registered, so the cache sees the flag one clock after it presents the address.

The mode bit controls how the second register is read. In mask mode, which is the default, the first register is a base address and the second register selects which address bits are compared against that base. In range mode, the two registers are the lower and upper limits of a contiguous window, and both limits are included in the window. Software changes the configuration through a simple write port: a write enable, a two-bit target select and a data word.

Top module: `nc_region_checker`

## Requirements
- R1: While the synchronous active-low reset is asserted, `nc_o` is 0. Reset clears both address registers to 0 and selects mask mode, so the first address checked after reset is flagged non-cacheable (an all-zero mask compares no bits).
- R2: In mask mode (mode bit 0), an address is non-cacheable exactly when, for every bit position where the second register holds 1, the address bit equals the same bit of the first register. Positions where the mask bit is 0 are ignored.
- R3: In range mode (mode bit 1), an address is non-cacheable exactly when it is at least the first register and at most the second register. Both limits are inclusive.
- R4: Range comparisons treat addresses and limits as unsigned 32-bit values. Addresses with bit 31 set compare as larger than addresses with bit 31 clear.
- R5: In range mode, when the first register is greater than the second, no address is flagged non-cacheable.
- R6: `nc_o` is registered. The value present after a rising clock edge reflects the `fetch_addr` that was applied before that edge.
- R7: Write targets are selected by `wr_sel`: 0 writes the first register (base or lower limit), 1 writes the second register (mask or upper limit), 2 writes the mode bit from `wr_data[0]`, and 3 changes nothing.
- R8: Changing the mode bit immediately changes how the existing second register is interpreted. Neither address register needs to be rewritten.
- R9: A write takes effect at the clock edge on which it is applied. An address applied in the same cycle as the write is judged against the configuration from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 first register, 1 second register, 2 mode bit, 3 none |
| wr_data | input | 32 | Write data; bit 0 carries the mode for target 2 |
| fetch_addr | input | 32 | Instruction fetch address to classify |
| nc_o | output | 1 | Registered flag: 1 means the previous address is non-cacheable |

## Verification
The hardest cases to reach from the ports are exact boundary hits. These are addresses equal to either inclusive limit, addresses one step outside a limit, and limits that straddle bit 31. Uniform random 32-bit addresses almost never land on them. To reach them, the stimulus draws a share of its addresses from the bench's own copy of the current limits, offset by -1, 0 or +1. It also places windows on purpose across the signed/unsigned divide and sets up inverted limits. Random mode flips, applied without rewriting the address registers, check that the second register is reinterpreted in both directions.

// File: rtl/nc_pkg.sv
// Package: shared encodings for the non-cacheable region checker.
// Assumes: write select is two bits wide; the mode bit lives in data bit 0.
package nc_pkg;

    // Write target encoding carried on wr_sel.
    typedef enum logic [1:0] {
        SEL_FIRST  = 2'd0,
        SEL_SECOND = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

    // Interpretation of the second register.
    typedef enum logic {
        MODE_MASK  = 1'b0,
        MODE_RANGE = 1'b1
    } region_mode_e;

endpackage

// File: rtl/nc_cfg_regs.sv
// Module: configuration registers of the region checker.
// Holds the first address, the second address (mask or upper limit) and the mode.
// Assumes: synchronous active-low reset; a single write target per cycle.
module nc_cfg_regs
    import nc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] first_q,
    output logic [ADDR_W-1:0] second_q,
    output region_mode_e      mode_q
);

    wr_sel_e sel;

    // Decode the raw select into the shared enumeration.
    always_comb begin
        sel = wr_sel_e'(wr_sel);
    end

    // Update the addressed register on a write; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
            mode_q   <= MODE_MASK;
        end else if (wr_en) begin
            case (sel)
                SEL_FIRST:  first_q  <= wr_data;
                SEL_SECOND: second_q <= wr_data;
                SEL_MODE:   mode_q   <= region_mode_e'(wr_data[0]);
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/nc_mask_match.sv
// Module: masked address compare.
// A mask bit of 1 makes that address bit significant; the hit requires
// agreement with the base on every significant bit.
// Assumes: purely combinational; result is registered by the parent.
module nc_mask_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);

    logic [ADDR_W-1:0] bit_ok;

    // One agreement term per address bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = !mask[i] || (addr[i] == base[i]);
    end

    // Every significant bit must agree.
    always_comb begin
        hit = &bit_ok;
    end

endmodule

// File: rtl/nc_range_match.sv
// Module: inclusive unsigned window compare.
// Assumes: limits are unsigned; an inverted window (lower > upper) never hits,
// which the two compares give without a separate term.
module nc_range_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lower,
    input  logic [ADDR_W-1:0] upper,
    output logic              hit
);

    logic above_low;
    logic below_high;

    // Both comparisons are unsigned and include equality.
    always_comb begin
        above_low  = (addr >= lower);
        below_high = (addr <= upper);
        hit        = above_low && below_high;
    end

endmodule

// File: rtl/nc_region_checker.sv
// Module: top of the non-cacheable region checker.
// Classifies a fetch address against one region and registers the flag.
// Assumes: synchronous active-low reset; flag latency is one cycle.
module nc_region_checker
    import nc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              nc_o
);

    logic [ADDR_W-1:0] first_q;
    logic [ADDR_W-1:0] second_q;
    region_mode_e      mode_q;
    logic              mask_hit;
    logic              range_hit;
    logic              nc_d;

    nc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .first_q  (first_q),
        .second_q (second_q),
        .mode_q   (mode_q)
    );

    nc_mask_match #(.ADDR_W(ADDR_W)) u_mask (
        .addr (fetch_addr),
        .base (first_q),
        .mask (second_q),
        .hit  (mask_hit)
    );

    nc_range_match #(.ADDR_W(ADDR_W)) u_range (
        .addr  (fetch_addr),
        .lower (first_q),
        .upper (second_q),
        .hit   (range_hit)
    );

    // Pick the decode that the mode bit selects.
    always_comb begin
        nc_d = (mode_q == MODE_RANGE) ? range_hit : mask_hit;
    end

    // Register the flag; reset forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n) nc_o <= 1'b0;
        else        nc_o <= nc_d;
    end

endmodule

// File: rtl/nc_region_checker_sva.sv
// Module: property checker for nc_region_checker, attached by bind.
// Assumes: observes configuration registers and ports; drives nothing.
module nc_region_checker_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] first_q,
    input logic [ADDR_W-1:0] second_q,
    input logic              range_mode,
    input logic              nc_o
);

    // R5: an inverted window flags nothing on the next cycle.
    a_r5_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (range_mode && (first_q > second_q)) |=> !nc_o);

    // R3: an address on the lower limit of a valid window is flagged.
    a_r3_lower_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (range_mode && (first_q <= second_q) && (fetch_addr == first_q)) |=> nc_o);

    // R3: an address on the upper limit of a valid window is flagged.
    a_r3_upper_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (range_mode && (first_q <= second_q) && (fetch_addr == second_q)) |=> nc_o);

    // R2: the base address itself always matches in mask mode.
    a_r2_base_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!range_mode && (fetch_addr == first_q)) |=> nc_o);

    // R7: select 3 leaves all configuration unchanged.
    a_r7_sel_none: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd3)) |=>
            ($stable(first_q) && $stable(second_q) && $stable(range_mode)));

endmodule

bind nc_region_checker nc_region_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .fetch_addr (fetch_addr),
    .first_q    (first_q),
    .second_q   (second_q),
    .range_mode (mode_q == nc_pkg::MODE_RANGE),
    .nc_o       (nc_o)
);

// File: tb/nc_region_checker_bench.sv
// Bench: directed corners plus seeded random stimulus, compared against a
// shadow model of the configuration kept in the bench.
module nc_region_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int MAX_CYCLES = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] fetch_addr = '0;
    logic          nc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] m_first  = '0;
    logic [AW-1:0] m_second = '0;
    logic          m_range  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nc_region_checker #(.ADDR_W(AW)) u_nc_region_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .fetch_addr (fetch_addr),
        .nc_o       (nc_o)
    );

    // Expected flag from the requirements (R2, R3, R4, R5).
    function automatic logic expect_nc(input logic rng, input logic [AW-1:0] a,
                                       input logic [AW-1:0] b, input logic [AW-1:0] addr);
        if (rng) begin
            expect_nc = 1'b0;
            if (a <= b && addr >= a && addr <= b) expect_nc = 1'b1;
        end else begin
            expect_nc = 1'b1;
            for (int i = 0; i < AW; i++)
                if (b[i] && (addr[i] != a[i])) expect_nc = 1'b0;
        end
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: nc_o=%0b expected %0b (addr=%h first=%h second=%h range=%0b)",
                     req, got, exp, fetch_addr, m_first, m_second, m_range);
        end
    endtask

    // One cycle: drive write and address, expect flag from the pre-write model (R6, R9).
    task automatic step(input logic we, input logic [1:0] sel, input logic [AW-1:0] d,
                        input logic [AW-1:0] addr, input string req);
        logic exp;
        wr_en = we; wr_sel = sel; wr_data = d; fetch_addr = addr;
        exp = expect_nc(m_range, m_first, m_second, addr);
        @(posedge clk);
        if (we) begin
            case (sel)
                2'd0: m_first  = d;
                2'd1: m_second = d;
                2'd2: m_range  = d[0];
                default: ;
            endcase
        end
        @(negedge clk);
        check(nc_o, exp, req);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        step(1'b1, sel, d, 32'h0, "R7");
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'd20240611));
        // R1: flag low during reset
        repeat (3) @(negedge clk);
        check(nc_o, 1'b0, "R1 reset");
        rst_n = 1'b1;
        // R1: reset state is mask mode with zero mask -> everything flagged
        step(1'b0, 2'd0, 32'h0, 32'hDEAD_BEEF, "R1 post-reset mask");

        // R2: mask mode corners
        wr(2'd0, 32'h8000_0000);
        wr(2'd1, 32'hF000_0000);
        step(1'b0, 2'd0, 0, 32'h8ABC_0000, "R2 hit");
        step(1'b0, 2'd0, 0, 32'h9000_0000, "R2 miss");
        step(1'b0, 2'd0, 0, 32'h0FFF_FFFF, "R2 miss low");

        // R3: inclusive range edges
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'h0000_1FFF);
        wr(2'd2, 32'h1);
        step(1'b0, 2'd0, 0, 32'h0000_0FFF, "R3 below");
        step(1'b0, 2'd0, 0, 32'h0000_1000, "R3 lower");
        step(1'b0, 2'd0, 0, 32'h0000_1FFF, "R3 upper");
        step(1'b0, 2'd0, 0, 32'h0000_2000, "R3 above");

        // R8: flip to mask mode; second register now a mask
        step(1'b1, 2'd2, 32'h0, 32'h0000_1000, "R8 same-cycle old mode");
        step(1'b0, 2'd0, 0, 32'h0000_3000, "R8 mask reinterpret");
        step(1'b1, 2'd2, 32'h1, 32'h0000_3000, "R8 back to range");
        step(1'b0, 2'd0, 0, 32'h0000_3000, "R8 range reinterpret");

        // R4: window straddling bit 31
        wr(2'd0, 32'h7FFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 0, 32'h8000_0000, "R4 high half");
        step(1'b0, 2'd0, 0, 32'hFFFF_FFFF, "R4 top");
        step(1'b0, 2'd0, 0, 32'h7FFF_FFFE, "R4 below");

        // R5: inverted window
        wr(2'd0, 32'h0000_0005);
        wr(2'd1, 32'h0000_0004);
        step(1'b0, 2'd0, 0, 32'h0000_0004, "R5 empty");
        step(1'b0, 2'd0, 0, 32'h0000_0005, "R5 empty");

        // R7: select 3 changes nothing; R9 write applies from next address
        wr(2'd1, 32'h0000_0010);
        step(1'b1, 2'd3, 32'h0000_0000, 32'h0000_0008, "R7 sel3 same cycle");
        step(1'b0, 2'd0, 0, 32'h0000_0008, "R7 sel3 ignored");
        step(1'b1, 2'd1, 32'h0000_0004, 32'h0000_0008, "R9 write same cycle");
        step(1'b0, 2'd0, 0, 32'h0000_0008, "R9 write applied");

        // R6: mixed random traffic, addresses biased to the current limits
        for (int n = 0; n < 3000; n++) begin
            int pick;
            int k;
            pick = $urandom_range(0, 9);
            k = $urandom_range(0, 2);
            if (pick < 3)      a = m_first + AW'(k) - 1;
            else if (pick < 6) a = m_second + AW'(k) - 1;
            else               a = $urandom;
            if ($urandom_range(0, 3) == 0)
                step(1'b1, 2'($urandom_range(0, 3)),
                     ($urandom_range(0, 1) == 1) ? AW'($urandom) : m_first ^ AW'($urandom_range(0, 255)),
                     a, "R6 random");
            else
                step(1'b0, 2'd0, 0, a, "R6 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule